// File: doc/BRIEF.md
# Serial Controller Status and Error Flag Unit

This block holds the operating flags of a serial-peripheral controller: the enable flag (clear means configuration mode, set means active mode), the master-select flag and six sticky error flags. It also produces the controller's interrupt lines. Software never writes the flags directly. Every change goes through a write-only command word in which each flag has its own clear bit and its own set bit, so a single write can change any mix of flags without a read-modify-write.

The shift engine sits next to this block and reports error conditions as one-cycle event pulses. Five of the error classes are captured only while their detection-enable bit is set. Mode errors are always captured. Once an error flag is set, it stays set until a command clears it. The error interrupt is a level: the OR of all error flags, gated by its enable bit. The receive, transmit, frame-end and transmit-finished interrupts are one-cycle pulses, registered from the matching event pulses and gated by their own enable bits.

Top module: `spi_flag_unit`

## Requirements
- R1: After reset, `status` reads 0 apart from bit 13, which follows `busy_in`, and every interrupt output is 0.
- R2: A command write with bit 1 set sets the enable flag (`status` bit 0), and bit 0 clears it. Bit 3 sets the master flag (`status` bit 1), and bit 2 clears it. The new value is visible in the cycle after the write.
- R3: Error event `ev_err[i]` sets `status` bit 7+i one cycle later. The classes are: i=0 mode, 1 transmit overflow, 2 receive overflow, 3 abort, 4 transmit underflow, 5 receive underflow. For i=1..5 the event counts only when `det_en[i-1]` is 1. Mode events are never masked.
- R4: Error flags are sticky. The clear bits are 6 (mode), 8 (tx overflow), 9 (rx overflow), 10 (abort), 11 (tx underflow) and 4 (rx underflow). The set bits are 7, 12, 13, 14, 15 and 5, in the same order. A set bit works whatever `det_en` holds.
- R5: When a flag's clear bit arrives in the same cycle as its set bit or its event, the clear wins and the flag reads 0.
- R6: Command 0x0F50 clears all six error flags and leaves the enable and master flags unchanged.
- R7: `irq_err` equals the OR of `status` bits 7 to 12, ANDed with `irq_en[2]`.
- R8: `irq_rx`, `irq_tx`, `irq_frame` and `irq_txdone` pulse high for the one cycle after `ev_rx`, `ev_tx`, `ev_frame` and `ev_txdone` respectively. Each pulse appears only if its enable bit is set: `irq_en` bit 0, 1, 3 and 4 respectively.
- R9: `status` bit 13 mirrors `busy_in`, and bits 2 to 6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd | input | 16 | Command word with paired set/clear bits |
| det_en | input | 5 | Detection enables: tx ovf, rx ovf, abort, tx unf, rx unf |
| ev_err | input | 6 | Error event pulses from the shift engine |
| busy_in | input | 1 | Shift engine busy |
| irq_en | input | 5 | Interrupt enables: rx, tx, error, frame end, tx finished |
| ev_rx | input | 1 | Receive event pulse |
| ev_tx | input | 1 | Transmit event pulse |
| ev_frame | input | 1 | Frame-end event pulse |
| ev_txdone | input | 1 | Transmit-finished event pulse |
| status | output | 14 | Status word |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_err | output | 1 | Error interrupt level |
| irq_frame | output | 1 | Frame-end interrupt |
| irq_txdone | output | 1 | Transmit-finished interrupt |

## Verification
The command word is swept one bit at a time across all 16 positions. A bit written to the wrong flag shows up in that sweep, and so does a bit that is dropped. Each error class is then fired with its detection enable off and with it on, which separates a correct mask from a stuck or swapped one. Three further sweeps cover the remaining interactions. The first writes set, clear and event for each flag in the same cycle, starting both from a set flag and from a clear flag, to show that clear has priority. The second walks all 32 interrupt-enable values against all 16 event combinations. The third holds flags set across idle cycles to show that they stick.

// File: rtl/spi_flag_unit.sv
module spi_flag_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [15:0] cmd,
  input  logic [4:0]  det_en,
  input  logic [5:0]  ev_err,
  input  logic        busy_in,
  input  logic [4:0]  irq_en,
  input  logic        ev_rx,
  input  logic        ev_tx,
  input  logic        ev_frame,
  input  logic        ev_txdone,
  output logic [13:0] status,
  output logic        irq_rx,
  output logic        irq_tx,
  output logic        irq_err,
  output logic        irq_frame,
  output logic        irq_txdone
);
  logic       en_q, ms_q;
  logic [5:0] err_q;
  logic [3:0] pulse_q;

  wire [5:0] err_clr = cmd_we ? {cmd[4], cmd[11], cmd[10], cmd[9], cmd[8], cmd[6]} : 6'd0;
  wire [5:0] err_set = cmd_we ? {cmd[5], cmd[15], cmd[14], cmd[13], cmd[12], cmd[7]} : 6'd0;
  wire [5:0] err_hit = ev_err & {det_en, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      ms_q    <= 1'b0;
      err_q   <= '0;
      pulse_q <= '0;
    end else begin
      if (cmd_we && cmd[0])      en_q <= 1'b0;
      else if (cmd_we && cmd[1]) en_q <= 1'b1;
      if (cmd_we && cmd[2])      ms_q <= 1'b0;
      else if (cmd_we && cmd[3]) ms_q <= 1'b1;
      err_q   <= (err_q | err_set | err_hit) & ~err_clr;
      pulse_q <= {ev_txdone & irq_en[4], ev_frame & irq_en[3],
                  ev_tx & irq_en[1], ev_rx & irq_en[0]};
    end
  end

  assign status     = {busy_in, err_q, 5'b00000, ms_q, en_q};
  assign irq_err    = (|err_q) & irq_en[2];
  assign irq_rx     = pulse_q[0];
  assign irq_tx     = pulse_q[1];
  assign irq_frame  = pulse_q[2];
  assign irq_txdone = pulse_q[3];
endmodule

module spi_flag_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_we,
  input logic [15:0] cmd,
  input logic [4:0]  det_en,
  input logic [5:0]  ev_err,
  input logic [4:0]  irq_en,
  input logic        ev_rx,
  input logic [13:0] status,
  input logic        irq_rx,
  input logic        irq_err
);
  a_r2_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd[1] && !cmd[0]) |=> status[0]);
  a_r3_masked_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_we && ev_err[1] && !det_en[0] && !status[8]) |=> !status[8]);
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status[8] && !(cmd_we && cmd[8])) |=> status[8]);
  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd[9]) |=> !status[9]);
  a_r7_err_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err == ((|status[12:7]) && irq_en[2]));
  a_r8_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx && irq_en[0]) |=> irq_rx);
endmodule

bind spi_flag_unit spi_flag_unit_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd(cmd), .det_en(det_en),
  .ev_err(ev_err), .irq_en(irq_en), .ev_rx(ev_rx), .status(status),
  .irq_rx(irq_rx), .irq_err(irq_err));

// File: tb/test_spi_flag_unit.sv
`timescale 1ns/1ps
module test_spi_flag_unit;
  logic clk = 0, rst_n = 0, cmd_we = 0, busy_in = 0;
  logic [15:0] cmd = 0;
  logic [4:0]  det_en = 0, irq_en = 0;
  logic [5:0]  ev_err = 0;
  logic ev_rx = 0, ev_tx = 0, ev_frame = 0, ev_txdone = 0;
  logic [13:0] status;
  logic irq_rx, irq_tx, irq_err, irq_frame, irq_txdone;
  int checks = 0, errors = 0;
  logic m_en = 0, m_ms = 0;
  logic [5:0] m_err = 0;
  logic [3:0] m_irq = 0;
  localparam int CLR_B [6] = '{6, 8, 9, 10, 11, 4};
  localparam int SET_B [6] = '{7, 12, 13, 14, 15, 5};

  always #2.5 clk = ~clk;

  spi_flag_unit i_spi_flag_unit (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare(string req);
    chk(req, {18'd0, status}, {18'd0, busy_in, m_err, 5'b0, m_ms, m_en});
    chk(req, {27'd0, irq_txdone, irq_frame, irq_tx, irq_rx, irq_err},
        {27'd0, m_irq, (|m_err) & irq_en[2]});
  endtask

  task automatic step(string req, logic we, logic [15:0] c, logic [5:0] ev, logic [3:0] pev);
    @(negedge clk);
    cmd_we = we; cmd = c; ev_err = ev;
    {ev_txdone, ev_frame, ev_tx, ev_rx} = pev;
    for (int i = 0; i < 6; i++) begin
      if (we && c[CLR_B[i]]) m_err[i] = 1'b0;
      else if ((we && c[SET_B[i]]) || (ev[i] && (i == 0 || det_en[i-1]))) m_err[i] = 1'b1;
    end
    if (we && c[0]) m_en = 0; else if (we && c[1]) m_en = 1;
    if (we && c[2]) m_ms = 0; else if (we && c[3]) m_ms = 1;
    m_irq = pev & {irq_en[4], irq_en[3], irq_en[1], irq_en[0]};
    @(posedge clk); #1;
    cmd_we = 0; cmd = 0; ev_err = 0;
    {ev_txdone, ev_frame, ev_tx, ev_rx} = 0;
    compare(req);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; compare("R1 reset");
    @(negedge clk); rst_n = 1;
    // R2 R4: each command bit alone, then everything cleared again
    for (int b = 0; b < 16; b++) begin
      step("R2 R4 single command bit", 1, 16'(1 << b), 0, 0);
      step("R4 sticky idle", 0, 0, 0, 0);
      step("R6 clear errors keeps enable", 1, 16'h0F50, 0, 0);
      step("R2 clear enable master", 1, 16'h0005, 0, 0);
    end
    // R3: each event with its detection enable off and on
    for (int d = 0; d < 2; d++) begin
      det_en = d ? 5'h1F : 5'h00;
      for (int i = 0; i < 6; i++) begin
        step("R3 event capture", 0, 0, 6'(1 << i), 0);
        step("R4 sticky after event", 0, 0, 0, 0);
        step("R6 bulk clear", 1, 16'h0F50, 0, 0);
      end
    end
    // R3: detection enables one at a time, all events firing
    for (int d = 0; d < 5; d++) begin
      det_en = 5'(1 << d);
      step("R3 single detect enable", 0, 0, 6'h3F, 0);
      step("R6 bulk clear", 1, 16'h0F50, 0, 0);
    end
    // R5: clear against set and event, from both starting values
    det_en = 5'h1F;
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 6; i++) begin
        if (s) step("R4 preset flag", 1, 16'(1 << SET_B[i]), 0, 0);
        step("R5 clear beats set and event", 1,
             16'((1 << SET_B[i]) | (1 << CLR_B[i])), 6'(1 << i), 0);
      end
    step("R5 enable clear beats set", 1, 16'h000F, 0, 0);
    step("R2 enable and master set", 1, 16'h000A, 0, 0);
    step("R6 all errors set", 1, 16'hF0A0, 0, 0);
    step("R6 bulk clear keeps enable master", 1, 16'h0F50, 0, 0);
    // R7 R8: every interrupt enable against every event mix
    for (int e = 0; e < 32; e++) begin
      irq_en = 5'(e);
      for (int p = 0; p < 16; p++) step("R8 pulse irq", 0, 0, 0, 4'(p));
      step("R7 error level", 1, 16'h0080, 0, 0);
      step("R8 pulse ends", 0, 0, 0, 0);
      step("R7 error cleared", 1, 16'h0F50, 0, 0);
    end
    // R9: busy mirror
    @(negedge clk); busy_in = 1; #1; compare("R9 busy high");
    @(negedge clk); busy_in = 0; #1; compare("R9 busy low");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule